// File: doc/BRIEF.md
# Flag Offset Configuration Loader

This block owns the two offset values that a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. Both are `OFS_W` bits wide and drive the flag logic continuously through `ae_ofs` and `af_ofs`. They can be loaded in two ways. One is a parallel byte lane that shares the FIFO's data path: while the load-select input `ld` is low, write and read strobes go to the offset registers instead of the FIFO memory. The other is a separate three-wire serial port (serial clock, serial data, serial enable).

Parallel accesses walk a slot counter through four byte slots in a fixed order and then wrap. Writes and reads share this counter. The serial port's three wires are brought into the core clock domain through a synchronizer. A rising serial clock edge is detected there and drives a small state machine. Its states are `SER_IDLE` (waiting for the first bit of a frame), `SER_SHIFT` (placing bits) and `SER_FULL` (every register bit has been written and further bits are dropped). Its transitions are: `SER_IDLE -> SER_SHIFT` on the first enabled edge, `SER_SHIFT -> SER_FULL` on the last register bit, and `SER_SHIFT/SER_FULL -> SER_IDLE` when the serial enable drops. The FSM places the bits most significant first.

Master reset restores both offsets to their default. Partial reset keeps the offsets but restarts both access paths.

Top module: `cfg_ofs_loader`

## Requirements
- R1: A clock edge with `wen` high and `ld` low stores `d_lane` into the currently selected slot. Slot 0 is `ae_ofs[7:0]`, slot 1 is `ae_ofs[15:8]`, slot 2 is `af_ofs[7:0]` and slot 3 is `af_ofs[15:8]`.
- R2: A clock edge with `ren` high and `ld` low loads the pre-edge contents of the selected slot into `cfg_q`. The new value is visible after that edge. In every other cycle `cfg_q` holds its value.
- R3: In each cycle with `ld` low and `wen` or `ren` high, the slot counter advances by exactly one and wraps from slot 3 to slot 0. A read and a write in the same cycle use the same slot: `cfg_q` receives the old byte and the register keeps the new one.
- R4: While `ld` is high, `wen`, `ren` and `d_lane` change neither offset nor `cfg_q`, and the slot counter keeps its value.
- R5: Each rising `sclk` edge seen while `sen` is high stores `sdi` into the next bit of the 32-bit word {`af_ofs`, `ae_ofs`}. Bits are placed starting from `af_ofs[15]`, through `af_ofs[0]`, then `ae_ofs[15]` down to `ae_ofs[0]`. The change is visible within four clock cycles of the `sclk` rise. Bits not yet reached keep their values.
- R6: After 32 bits of one frame, further `sclk` edges change nothing until `sen` drops.
- R7: Once `sen` has been low, the next frame starts again at `af_ofs[15]`. Edges while `sen` is low change nothing.
- R8: Master reset `mrst` sets both offsets to 7 and `cfg_q` to 0, returns the slot counter to slot 0 and restarts the serial frame.
- R9: Partial reset `prst` keeps both offsets, clears `cfg_q`, returns the slot counter to slot 0 and restarts the serial frame.
- R10: If a serial bit and a parallel byte write hit the same register bit in the same cycle, the parallel byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for both the write and read sides |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ld | input | 1 | Load select: low routes strobes to the offset registers |
| wen | input | 1 | Write strobe |
| ren | input | 1 | Read strobe |
| d_lane | input | 8 | Parallel write byte |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data bit |
| sen | input | 1 | Serial enable, frames a serial load |
| ae_ofs | output | 16 | Almost-empty offset to the flag logic |
| af_ofs | output | 16 | Almost-full offset to the flag logic |
| cfg_q | output | 8 | Parallel read-back byte |

## Verification
A wrong slot counter appears on the very next parallel access: the byte lands in the wrong half of an offset, or the read-back returns a neighbouring byte. A wrong serial bit position or frame state shows up in the offsets one synchronizer delay after the offending `sclk` edge. This is visible as a shifted word, an overflow past 32 bits that corrupts the low bits, or a frame that fails to restart at the top bit. Reset faults are visible on the first cycle after the reset pulse, as offsets that differ from 7 or from their retained values.

// File: rtl/cfg_ofs_pkg.sv
package cfg_ofs_pkg;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_FULL  = 2'd2
    } ser_state_t;

endpackage

// File: rtl/cfg_ofs_sync.sv
module cfg_ofs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sdi,
    input  logic sen,
    output logic rise_o,
    output logic bit_o,
    output logic en_o
);
    localparam int LANES = 3;

    logic [LANES-1:0] pipe [STAGES];
    logic             sclk_d;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= {sclk, sdi, sen};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= pipe[STAGES-1][2];
    end

    assign rise_o = pipe[STAGES-1][2] & ~sclk_d;
    assign bit_o  = pipe[STAGES-1][1];
    assign en_o   = pipe[STAGES-1][0];

endmodule

// File: rtl/cfg_ofs_serfsm.sv
module cfg_ofs_serfsm
    import cfg_ofs_pkg::*;
#(
    parameter int TOT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rise_i,
    input  logic                     en_i,
    output logic                     bit_we,
    output logic [$clog2(TOT_W)-1:0] bit_idx
);
    localparam int IDX_W = $clog2(TOT_W);
    localparam int POS_W = $clog2(TOT_W + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(TOT_W - 1);
    localparam logic [POS_W-1:0] POS_END  = POS_W'(TOT_W);

    ser_state_t       state, state_n;
    logic [POS_W-1:0] pos, pos_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            pos   <= '0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        pos_n   = pos;
        unique case (state)
            SER_IDLE: begin
                if (rise_i && en_i) begin
                    pos_n   = pos + 1'b1;
                    state_n = (pos == POS_LAST) ? SER_FULL : SER_SHIFT;
                end
            end
            SER_SHIFT: begin
                if (!en_i) begin
                    pos_n   = '0;
                    state_n = SER_IDLE;
                end else if (rise_i) begin
                    pos_n = pos + 1'b1;
                    if (pos == POS_LAST) state_n = SER_FULL;
                end
            end
            SER_FULL: begin
                if (!en_i) begin
                    pos_n   = '0;
                    state_n = SER_IDLE;
                end
            end
            default: begin
                pos_n   = '0;
                state_n = SER_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        bit_we  = 1'b0;
        bit_idx = IDX_W'(TOT_W - 1) - IDX_W'(pos);
        unique case (state)
            SER_IDLE, SER_SHIFT: bit_we = rise_i && en_i;
            SER_FULL:            bit_we = 1'b0;
            default:             bit_we = 1'b0;
        endcase
    end

    // R6: the bit position never runs past the register length
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_END);

    // R6: the full state is reached only once every bit has been placed
    a_r6_full_count: assert property (@(posedge clk) disable iff (rst)
        (state == SER_FULL) |-> (pos == POS_END));

    // R7: a dropped enable restarts the frame at its top bit
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (pos == '0));

endmodule

// File: rtl/cfg_ofs_parseq.sv
module cfg_ofs_parseq #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step_i,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)              slot_o <= '0;
        else if (step_i) begin
            if (slot_o == SLOT_LAST) slot_o <= '0;
            else                     slot_o <= slot_o + 1'b1;
        end
    end

    // R4: with no access the slot counter keeps its place
    a_r4_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(slot_o));

    // R3: the last slot wraps back to the first
    a_r3_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (step_i && slot_o == SLOT_LAST) |=> (slot_o == '0));

endmodule

// File: rtl/cfg_ofs_loader.sv
module cfg_ofs_loader
    import cfg_ofs_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int OFS_W       = 16,
    parameter int DEF_OFS     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              ld,
    input  logic              wen,
    input  logic              ren,
    input  logic [LANE_W-1:0] d_lane,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              sen,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic [LANE_W-1:0] cfg_q
);
    localparam int TOT_W     = 2 * OFS_W;
    localparam int NUM_SLOTS = TOT_W / LANE_W;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int IDX_W     = $clog2(TOT_W);
    localparam logic [TOT_W-1:0] CFG_DEF = {OFS_W'(DEF_OFS), OFS_W'(DEF_OFS)};

    logic              path_rst;
    logic              rise_s, bit_s, en_s;
    logic              ser_we;
    logic [IDX_W-1:0]  ser_idx;
    logic [SLOT_W-1:0] slot;
    logic              par_sel, par_we, par_re, step;
    logic [TOT_W-1:0]  cfg_r, cfg_n;

    assign path_rst = mrst | prst;
    assign par_sel  = ~ld;
    assign par_we   = par_sel & wen;
    assign par_re   = par_sel & ren;
    assign step     = par_we | par_re;

    cfg_ofs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (path_rst),
        .sclk   (sclk),
        .sdi    (sdi),
        .sen    (sen),
        .rise_o (rise_s),
        .bit_o  (bit_s),
        .en_o   (en_s)
    );

    cfg_ofs_serfsm #(.TOT_W(TOT_W)) u_ser (
        .clk     (clk),
        .rst     (path_rst),
        .rise_i  (rise_s),
        .en_i    (en_s),
        .bit_we  (ser_we),
        .bit_idx (ser_idx)
    );

    cfg_ofs_parseq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk    (clk),
        .rst    (path_rst),
        .step_i (step),
        .slot_o (slot)
    );

    // serial bit first, parallel byte on top of it
    always_comb begin
        cfg_n = cfg_r;
        if (ser_we) cfg_n[ser_idx] = bit_s;
        if (par_we) cfg_n[int'(slot) * LANE_W +: LANE_W] = d_lane;
    end

    always_ff @(posedge clk) begin
        if (mrst)      cfg_r <= CFG_DEF;
        else if (prst) cfg_r <= cfg_r;
        else           cfg_r <= cfg_n;
    end

    always_ff @(posedge clk) begin
        if (path_rst)    cfg_q <= '0;
        else if (par_re) cfg_q <= cfg_r[int'(slot) * LANE_W +: LANE_W];
    end

    assign ae_ofs = cfg_r[OFS_W-1:0];
    assign af_ofs = cfg_r[TOT_W-1:OFS_W];

    // R8: master reset restores the defaults and clears the read byte
    a_r8_mrst_default: assert property (@(posedge clk)
        mrst |=> (ae_ofs == OFS_W'(DEF_OFS) && af_ofs == OFS_W'(DEF_OFS) && cfg_q == '0));

    // R9: partial reset keeps both offsets
    a_r9_prst_keep: assert property (@(posedge clk) disable iff (mrst)
        prst |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // R4: with load-select high and no serial bit the offsets do not move
    a_r4_ld_quiet: assert property (@(posedge clk) disable iff (path_rst)
        (ld && !ser_we) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // R2: the read byte changes only on a configuration read
    a_r2_q_hold: assert property (@(posedge clk) disable iff (path_rst)
        !par_re |=> $stable(cfg_q));

endmodule

// File: tb/sim_cfg_ofs_loader.sv
`timescale 1ns/1ps
module sim_cfg_ofs_loader;

    logic        clk = 1'b0;
    logic        mrst, prst, ld, wen, ren, sclk, sdi, sen;
    logic [7:0]  d_lane;
    logic [15:0] ae_ofs, af_ofs;
    logic [7:0]  cfg_q;

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    logic [31:0] exp_cfg;
    int          exp_slot;
    int          exp_pos;

    always #2.5 clk = ~clk;

    cfg_ofs_loader u0 (
        .clk(clk), .mrst(mrst), .prst(prst), .ld(ld), .wen(wen), .ren(ren),
        .d_lane(d_lane), .sclk(sclk), .sdi(sdi), .sen(sen),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ofs(input string req);
        chk(req, {af_ofs, ae_ofs}, exp_cfg);
    endtask

    task automatic par_write(input logic [7:0] b);
        @(negedge clk);
        ld = 1'b0; wen = 1'b1; d_lane = b;
        @(negedge clk);
        wen = 1'b0; ld = 1'b1;
        exp_cfg[exp_slot*8 +: 8] = b;
        exp_slot = (exp_slot + 1) % 4;
    endtask

    task automatic par_read(input string req);
        logic [7:0] e;
        e = exp_cfg[exp_slot*8 +: 8];
        @(negedge clk);
        ld = 1'b0; ren = 1'b1;
        @(negedge clk);
        ren = 1'b0; ld = 1'b1;
        exp_slot = (exp_slot + 1) % 4;
        chk(req, {24'd0, cfg_q}, {24'd0, e});
    endtask

    task automatic ser_bit(input logic b, input logic en);
        @(negedge clk);
        sclk = 1'b0; sdi = b; sen = en;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        if (en) begin
            if (exp_pos < 32) exp_cfg[31-exp_pos] = b;
            exp_pos++;
        end
    endtask

    task automatic ser_drop();
        @(negedge clk);
        sclk = 1'b0; sen = 1'b0;
        repeat (5) @(negedge clk);
        exp_pos = 0;
    endtask

    task automatic ser_word(input logic [63:0] w, input int n);
        for (int i = 0; i < n; i++) ser_bit(w[63-i], 1'b1);
    endtask

    task automatic pulse_rst(input bit master);
        @(negedge clk);
        if (master) mrst = 1'b1; else prst = 1'b1;
        @(negedge clk);
        mrst = 1'b0; prst = 1'b0;
        exp_slot = 0;
        exp_pos  = 0;
        if (master) exp_cfg = {16'd7, 16'd7};
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mrst = 1'b1; prst = 1'b0; ld = 1'b1; wen = 1'b0; ren = 1'b0;
        d_lane = '0; sclk = 1'b0; sdi = 1'b0; sen = 1'b0;
        exp_cfg = {16'd7, 16'd7}; exp_slot = 0; exp_pos = 0;
        repeat (3) @(negedge clk);
        mrst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk_ofs("R8 reset offsets");
        chk("R8 reset cfg_q", {24'd0, cfg_q}, 32'd0);

        // R1 R2 R3: sweep of byte patterns through all four slots
        for (int it = 0; it < 64; it++) begin
            for (int k = 0; k < 4; k++) par_write(8'((it * 37 + k * 91 + 5) & 8'hFF));
            chk_ofs("R1 parallel write sweep");
            for (int k = 0; k < 4; k++) par_read("R2 parallel read sweep");
        end

        // R3: interleaved access walks one shared counter
        par_write(8'hA1);
        par_read("R3 read after write uses next slot");
        par_write(8'hB2);
        par_read("R3 wrap to slot 0");
        chk_ofs("R3 interleaved contents");

        // R3: same-cycle read and write
        begin
            logic [7:0] old_b;
            old_b = exp_cfg[exp_slot*8 +: 8];
            @(negedge clk);
            ld = 1'b0; wen = 1'b1; ren = 1'b1; d_lane = 8'h5C;
            @(negedge clk);
            wen = 1'b0; ren = 1'b0; ld = 1'b1;
            exp_cfg[exp_slot*8 +: 8] = 8'h5C;
            exp_slot = (exp_slot + 1) % 4;
            chk("R3 combined access old byte", {24'd0, cfg_q}, {24'd0, old_b});
            chk_ofs("R3 combined access new byte");
        end

        // R4: strobes with load-select high are ignored
        begin
            logic [7:0] q_before;
            q_before = cfg_q;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                ld = 1'b1; wen = i[0]; ren = i[1]; d_lane = 8'(8'hE0 + i);
            end
            @(negedge clk);
            wen = 1'b0; ren = 1'b0;
            @(negedge clk);
            chk_ofs("R4 ld high offsets unchanged");
            chk("R4 ld high cfg_q unchanged", {24'd0, cfg_q}, {24'd0, q_before});
            par_read("R4 counter held while ld high");
        end

        // R5: full serial words
        for (int w = 0; w < 3; w++) begin
            logic [31:0] word;
            word = 32'h9E37_79B9 * (w + 1) + 32'h0102_0304;
            ser_word({word, 32'd0}, 32);
            chk_ofs("R5 serial full word");
            ser_drop();
        end

        // R5: partial frame touches only the top bits
        ser_word(64'hA800_0000_0000_0000, 5);
        chk_ofs("R5 partial frame");
        ser_drop();
        chk_ofs("R5 partial frame after drop");

        // R6: bits past the end are dropped
        ser_word(64'h1234_5678_FFFF_FFFF, 40);
        chk_ofs("R6 overflow ignored");
        ser_drop();

        // R7: restart after enable drop, and edges without enable
        ser_word(64'h3C00_0000_0000_0000, 8);
        ser_drop();
        ser_word(64'hC300_0000_0000_0000, 8);
        chk_ofs("R7 frame restarts at top bit");
        for (int i = 0; i < 4; i++) ser_bit(1'b1, 1'b0);
        chk_ofs("R7 edges with enable low ignored");
        ser_drop();

        // R9: partial reset keeps offsets, restarts the paths
        par_read("R9 setup read");
        pulse_rst(1'b0);
        chk_ofs("R9 offsets retained");
        chk("R9 cfg_q cleared", {24'd0, cfg_q}, 32'd0);
        par_read("R9 counter back at slot 0");

        // R10: serial bit and parallel byte land on the same edge
        pulse_rst(1'b0);
        for (int i = 0; i < 3; i++) par_read("R10 setup read");
        @(negedge clk);
        sclk = 1'b0; sdi = 1'b1; sen = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        ld = 1'b0; wen = 1'b1; d_lane = 8'h00;
        @(negedge clk);
        wen = 1'b0; ld = 1'b1;
        exp_cfg[31] = 1'b1;
        exp_cfg[31:24] = 8'h00;
        exp_slot = 0;
        exp_pos = 1;
        repeat (2) @(negedge clk);
        chk_ofs("R10 parallel byte wins");
        ser_bit(1'b1, 1'b1);
        chk_ofs("R10 serial frame continued");
        ser_drop();

        // R8: master reset restores defaults
        pulse_rst(1'b1);
        chk_ofs("R8 master reset defaults");
        chk("R8 master reset cfg_q", {24'd0, cfg_q}, 32'd0);
        par_read("R8 counter back at slot 0");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule